// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block gives a clock synthesizer a small bank of control registers, such as per-output enable bits, that a system controller can set over a two-wire serial bus at start-up. It watches the open-drain clock and data lines, recognises start and stop conditions, matches its 7-bit device address and decodes an 8-bit command code. The block supports four transfers: byte write, byte read, block write and block read. The register contents drive the clock core in parallel at all times.

The bus lines are sampled by the block's own system clock, which must run many times faster than the serial clock. The block never stretches the serial clock. It only pulls the data line low, through an output-enable pin. The command code's top bit chooses between a single indexed byte and a block transfer. A block transfer always starts at register 0 and moves upward one register at a time. A byte-count byte follows the command in a block write, and it is also the first byte returned in a block read.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The block answers only to device address 69h, which is address byte D2h for writes and D3h for reads. For any other address it leaves the acknowledge bit released and ignores the bus until the next start condition.
- R2: The block acknowledges, by pulling SDA low during the ninth clock, a matching address byte, the command byte, the block count byte and every data byte it receives.
- R3: In the command byte, bit 7 = 1 selects a single-byte access at the offset in bits 6:0. Bit 7 = 0 selects a block access that starts at register 0, whatever bits 6:0 hold.
- R4: A byte write stores the first data byte in the register at the offset. Further data bytes in the same transfer are acknowledged and discarded.
- R5: A byte read returns the register at the offset, most significant bit first. The sequence is write address, command, repeated start, then address D3h. SDA is released after the master's NACK.
- R6: A block write takes a count byte and then stores data bytes into registers 0, 1, 2 and upward, one after another. Data bytes beyond the count are acknowledged and discarded.
- R7: A block read first returns the number of implemented registers, and then registers from 0 upward for as long as the master acknowledges.
- R8: A stop after any complete byte of a block write keeps the bytes already written and leaves later registers untouched. The next transfer then works normally.
- R9: Writes to an offset at or beyond the register count are acknowledged and discarded. Reads from such offsets return 00h.
- R10: Reset loads every register with the reset byte (FFh by default) and releases SDA.
- R11: Register i appears on reg_bus bits [8i+7:8i], and reg_bus changes only on a register write.
- R12: A start condition always restarts the address phase, and a stop always returns the block to idle. Both leave SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| reg_bus | output | NUM_REGS*8 | Parallel register contents, register 0 in the low byte |

## Verification
The hardest situation to reach is a stop that arrives partway through a block write, after some counted bytes have been written but before the count is used up. The slave must then drop its remaining count without writing anything more. The bench reaches this state with a block write that announces six bytes and sends only two before a stop. It then checks that registers 2 and above are unchanged, and it runs a byte read to confirm the slave accepts a new transfer. A mismatched address followed by more bytes and a repeated start is driven in the same way, to show the ignored state ends only at a start condition.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        bus_state_e state;
        bus_state_e nxt;
        logic       ack_ph;
        logic       ack_drv;
        logic       m_ack;
        logic [3:0] bits;
        logic [7:0] shreg;
        logic [6:0] ptr;
        logic       hdr;
        logic [7:0] rem;
        logic       wr_en;
        logic [6:0] wr_idx;
        logic [7:0] wr_data;
    } proto_t;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  scl_s;

    always_comb begin
        sy_d          = sy_q;
        sy_d.scl_pipe = {sy_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        sy_d.sda_pipe = {sy_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        sy_d.scl_prev = sy_q.scl_pipe[SYNC_STAGES-1];
        sy_d.sda_prev = sy_q.sda_pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign scl_s     = sy_q.scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sy_q.sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~sy_q.scl_prev;
    assign scl_fall  = ~scl_s & sy_q.scl_prev;
    assign start_det = scl_s & sy_q.scl_prev & sy_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sy_q.scl_prev & ~sy_q.sda_prev & sda_s;

endmodule

// File: rtl/smbus_cfg_proto.sv
module smbus_cfg_proto
    import smbus_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_idx,
    output logic       wr_en,
    output logic [6:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    proto_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_det) begin
            d.state   = ST_ADDR;
            d.bits    = '0;
            d.ack_ph  = 1'b0;
            d.ack_drv = 1'b0;
        end else if (stop_det) begin
            d.state   = ST_IDLE;
            d.bits    = '0;
            d.ack_ph  = 1'b0;
            d.ack_drv = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE, ST_SKIP: ;
                ST_RDATA: begin
                    if (!q.ack_ph) begin
                        if (scl_fall) begin
                            if (q.bits == 4'd7) begin
                                d.ack_ph = 1'b1;
                                d.bits   = '0;
                            end else begin
                                d.shreg = q.shreg << 1;
                                d.bits  = q.bits + 4'd1;
                            end
                        end
                    end else begin
                        if (scl_rise) d.m_ack = ~sda_s;
                        if (scl_fall) begin
                            d.ack_ph = 1'b0;
                            if (q.m_ack) begin
                                d.bits = '0;
                                if (q.hdr) begin
                                    d.shreg = COUNT_BYTE;
                                    d.hdr   = 1'b0;
                                end else begin
                                    d.shreg = rd_data;
                                    d.ptr   = q.ptr + 7'd1;
                                end
                            end else begin
                                d.state = ST_SKIP;
                            end
                        end
                    end
                end
                default: begin
                    if (!q.ack_ph) begin
                        if (scl_rise && q.bits != 4'd8) begin
                            d.shreg = {q.shreg[6:0], sda_s};
                            d.bits  = q.bits + 4'd1;
                        end
                        if (scl_fall && q.bits == 4'd8) begin
                            d.bits    = '0;
                            d.ack_ph  = 1'b1;
                            d.ack_drv = 1'b1;
                            case (q.state)
                                ST_ADDR: begin
                                    if (q.shreg[7:1] == DEV_ADDR) begin
                                        d.nxt = q.shreg[0] ? ST_RDATA : ST_CMD;
                                    end else begin
                                        d.state   = ST_SKIP;
                                        d.ack_ph  = 1'b0;
                                        d.ack_drv = 1'b0;
                                    end
                                end
                                ST_CMD: begin
                                    d.hdr = ~q.shreg[7];
                                    d.ptr = q.shreg[7] ? q.shreg[6:0] : 7'd0;
                                    d.rem = q.shreg[7] ? 8'd1 : 8'd0;
                                    d.nxt = q.shreg[7] ? ST_WDATA : ST_COUNT;
                                end
                                ST_COUNT: begin
                                    d.rem = q.shreg;
                                    d.hdr = 1'b0;
                                    d.nxt = ST_WDATA;
                                end
                                default: begin
                                    d.nxt = ST_WDATA;
                                    if (q.rem != 8'd0) begin
                                        d.rem     = q.rem - 8'd1;
                                        d.ptr     = q.ptr + 7'd1;
                                        d.wr_en   = (int'(q.ptr) < NUM_REGS);
                                        d.wr_idx  = q.ptr;
                                        d.wr_data = q.shreg;
                                    end
                                end
                            endcase
                        end
                    end else if (scl_fall) begin
                        d.ack_ph  = 1'b0;
                        d.ack_drv = 1'b0;
                        d.state   = q.nxt;
                        if (q.nxt == ST_RDATA) begin
                            if (q.hdr) begin
                                d.shreg = COUNT_BYTE;
                                d.hdr   = 1'b0;
                            end else begin
                                d.shreg = rd_data;
                                d.ptr   = q.ptr + 7'd1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.nxt     <= ST_IDLE;
            q.ack_ph  <= 1'b0;
            q.ack_drv <= 1'b0;
            q.m_ack   <= 1'b0;
            q.bits    <= '0;
            q.shreg   <= '0;
            q.ptr     <= '0;
            q.hdr     <= 1'b0;
            q.rem     <= '0;
            q.wr_en   <= 1'b0;
            q.wr_idx  <= '0;
            q.wr_data <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_idx  = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_idx  = q.wr_idx;
    assign wr_data = q.wr_data;
    assign sda_oe  = q.ack_drv | ((q.state == ST_RDATA) & ~q.ack_ph & ~q.shreg[7]);

endmodule

// File: rtl/smbus_cfg_regfile.sv
module smbus_cfg_regfile #(
    parameter int         NUM_REGS = 8,
    parameter logic [7:0] RST_BYTE = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [6:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [6:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] reg_bus
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && wr_idx == 7'(g)) val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= RST_BYTE;
            else        val_q <= val_d;
        end

        assign reg_bus[g*8 +: 8] = val_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 7'(i)) rd_data = reg_bus[i*8 +: 8];
        end
    end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] RST_BYTE    = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_bus
);

    logic       sda_s_w, scl_rise_w, scl_fall_w, start_det_w, stop_det_w;
    logic       wr_en_w;
    logic [6:0] wr_idx_w, rd_idx_w;
    logic [7:0] wr_data_w, rd_data_w;

    smbus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s_w),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_det_w),
        .stop_det  (stop_det_w)
    );

    smbus_cfg_proto #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) i_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s_w),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_det_w),
        .stop_det  (stop_det_w),
        .rd_data   (rd_data_w),
        .rd_idx    (rd_idx_w),
        .wr_en     (wr_en_w),
        .wr_idx    (wr_idx_w),
        .wr_data   (wr_data_w),
        .sda_oe    (sda_oe)
    );

    smbus_cfg_regfile #(.NUM_REGS(NUM_REGS), .RST_BYTE(RST_BYTE)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (wr_data_w),
        .rd_idx  (rd_idx_w),
        .rd_data (rd_data_w),
        .reg_bus (reg_bus)
    );

endmodule

// File: rtl/smbus_cfg_checker.sv
module smbus_cfg_checker #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  wr_en,
    input logic [6:0]            wr_idx,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] reg_bus
);

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !sda_oe); // R12
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R12
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (int'(wr_idx) < NUM_REGS)); // R9
    AST_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(reg_bus)); // R11
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(scl_fall)); // R2
    AST_WRITE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(scl_fall)); // R4

endmodule

bind smbus_cfg_slave smbus_cfg_checker #(.NUM_REGS(NUM_REGS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall_w),
    .start_det (start_det_w),
    .stop_det  (stop_det_w),
    .wr_en     (wr_en_w),
    .wr_idx    (wr_idx_w),
    .sda_oe    (sda_oe),
    .reg_bus   (reg_bus)
);

// File: tb/test_smbus_cfg_slave.sv
module test_smbus_cfg_slave;

    localparam int NREG = 8;
    localparam int Q    = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_m = 1'b1;
    logic done  = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] reg_bus;
    logic sda_line;

    logic [7:0] model [NREG];
    int errs   = 0;
    int checks = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    smbus_cfg_slave #(.NUM_REGS(NREG)) i_smbus_cfg_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .reg_bus (reg_bus)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_bus();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl = 1'b1; qwait();
        b = sda_line; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
        chk("R10 reset value", reg_bus, model_bus());
        chk("R10 sda released", sda_oe, 1'b0);
    endtask

    task automatic t_byte_write();
        logic [3:0] a;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte(8'h83, a[1]);
        send_byte(8'hA5, a[2]);
        send_byte(8'h3C, a[3]);
        bus_stop();
        model[3] = 8'hA5;
        chk("R2 acks on byte write", a, 4'hF);
        chk("R4 byte write, extra byte dropped", reg_bus, model_bus());
    endtask

    task automatic t_byte_read(input logic [6:0] off, input logic [7:0] exp, input string req);
        logic [2:0] a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte({1'b1, off}, a[1]);
        bus_start();
        send_byte(8'hD3, a[2]);
        recv_byte(v, 1'b0);
        bus_stop();
        chk({req, " acks"}, a, 3'b111);
        chk({req, " data"}, v, exp);
        chk("R12 sda released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_block_write();
        logic [5:0] a;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte(8'h05, a[1]);
        send_byte(8'h03, a[2]);
        send_byte(8'h11, a[3]);
        send_byte(8'h22, a[4]);
        send_byte(8'h33, a[5]);
        send_byte(8'h44, a[5]);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        chk("R6 block write acks", a, 6'h3F);
        chk("R6 R3 block write from register 0, count honoured", reg_bus, model_bus());
    endtask

    task automatic t_block_read();
        logic [2:0] a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte(8'h00, a[1]);
        bus_start();
        send_byte(8'hD3, a[2]);
        chk("R7 block read acks", a, 3'b111);
        recv_byte(v, 1'b1);
        chk("R7 count byte", v, 8'(NREG));
        for (int i = 0; i < NREG; i++) begin
            recv_byte(v, 1'b1);
            chk("R7 block read data", v, model[i]);
        end
        recv_byte(v, 1'b0);
        bus_stop();
        chk("R9 read past last register", v, 8'h00);
    endtask

    task automatic t_early_stop();
        logic [4:0] a;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte(8'h00, a[1]);
        send_byte(8'h06, a[2]);
        send_byte(8'h55, a[3]);
        send_byte(8'h66, a[4]);
        bus_stop();
        model[0] = 8'h55; model[1] = 8'h66;
        chk("R8 early stop acks", a, 5'h1F);
        chk("R8 early stop keeps written, rest untouched", reg_bus, model_bus());
        t_byte_read(7'd1, 8'h66, "R8 transfer after early stop");
    endtask

    task automatic t_wrong_addr();
        logic a0, a1, a2;
        logic [2:0] b;
        bus_start();
        send_byte(8'hD4, a0);
        send_byte(8'h83, a1);
        send_byte(8'h77, a2);
        chk("R1 no ack on wrong address or after it", {a0, a1, a2}, 3'b000);
        bus_start();
        send_byte(8'hD2, b[0]);
        send_byte(8'h84, b[1]);
        send_byte(8'h5A, b[2]);
        bus_stop();
        model[4] = 8'h5A;
        chk("R1 repeated start after mismatch acks", b, 3'b111);
        chk("R1 mismatch ignored, later write lands", reg_bus, model_bus());
    endtask

    task automatic t_out_of_range();
        logic [2:0] a;
        bus_start();
        send_byte(8'hD2, a[0]);
        send_byte(8'h8A, a[1]);
        send_byte(8'h99, a[2]);
        bus_stop();
        chk("R9 out of range write acked", a, 3'b111);
        chk("R9 out of range write discarded", reg_bus, model_bus());
        t_byte_read(7'h0A, 8'h00, "R9 out of range read");
    endtask

    task automatic t_reset_again();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
        chk("R10 R11 reset restores defaults", reg_bus, model_bus());
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_byte_write();
        t_byte_read(7'd3, 8'hA5, "R5 byte read");
        t_byte_read(7'd0, 8'hFF, "R5 byte read default");
        t_block_write();
        t_block_read();
        t_early_stop();
        t_wrong_addr();
        t_out_of_range();
        t_reset_again();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule